// File: doc/BRIEF.md
# Gated Clock Output Controller

This block sits behind a set of free-running source clocks: one each for the processor, the chipset link, the graphics port, the PCI bus, the interrupt controller, a 48 MHz source and the reference oscillator. It produces one gated copy of its source for every board-level clock output. An output runs only when all of these allow it: its own enable bit, the power state, the tri-state override, and, for the PCI and processor groups, a group stop pin. Every gate is a latch-based clock gate that changes state only while its source is low. Starting or stopping an output therefore never cuts a pulse short.

The stop pins and the power-down pin are asynchronous. Each clock domain passes them through its own two-flop synchronizer. The two lowest PCI outputs never obey the PCI stop pin. Each processor output obeys the processor stop pin only when its own mask bit is set. One auxiliary output runs at half the 48 MHz source rate or at the full rate. The change between the two rates happens only at an instant when both candidate clocks are low. The USB output can be driven in antiphase to the 48 MHz source. The tri-state override drives `clk_oe` low, which the pad ring uses to release every output, and it also closes every gate.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: Each output has an enable bit. When the bit is 1 and no other condition blocks the output, it runs at its source rate. When the bit is 0, the output stays low.
- R2: When `pci_halt_n` is 0, `pci_clk[N_PCI_FREE+N_PCI_GATED-1:N_PCI_FREE]` stay low. `pci_clk[N_PCI_FREE-1:0]` are never affected by `pci_halt_n`.
- R3: When `cpu_halt_n` is 0, `cpu_clk[i]` stays low if `cpu_halt_mask[i]` is 1. If `cpu_halt_mask[i]` is 0, `cpu_clk[i]` keeps running.
- R4: When `hiz_all` is 1, `clk_oe` is 0 and every clock output stays low, whatever the other inputs are. When `hiz_all` is 0, `clk_oe` is 1.
- R5: When `pwrdn_n` is 0, every clock output stays low and `clk_oe` stays 1. This takes priority over the enable bits and the stop pins.
- R6: `aux_clk` runs at half the `src_48m` rate when `aux_half_rate` is 1, and at the full rate when it is 0. The rate changes only at a falling edge of `src_48m` while the half-rate clock is low.
- R7: When `usb_invert` is 1, a running `usb_clk` is the complement of `src_48m`. When it is 0, `usb_clk` follows `src_48m`.
- R8: A falling `pwrdn_n` or stop pin passes through two flops of the output's own domain. A running output therefore gives exactly two more rising edges after the pin falls. After a release, no rising edge appears within the next two source cycles.
- R9: Every high pulse on every output has the full high width of its source clock. No enable, stop, power-down, tri-state or rate change truncates a pulse.
- R10: While `rst_n` is 0, all clock outputs are low and `clk_oe` follows `hiz_all`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the synchronizers and the rate logic |
| src_cpu | input | 1 | Processor source clock |
| src_link | input | 1 | Chipset link source clock |
| src_agp | input | 1 | Graphics port source clock |
| src_pci | input | 1 | PCI source clock |
| src_apic | input | 1 | Interrupt controller source clock |
| src_48m | input | 1 | 48 MHz source clock |
| src_ref | input | 1 | Reference source clock |
| pwrdn_n | input | 1 | Asynchronous power-down, active low |
| pci_halt_n | input | 1 | Asynchronous PCI group stop, active low |
| cpu_halt_n | input | 1 | Asynchronous processor group stop, active low |
| en_cpu | input | N_CPU | Enable bits of the processor outputs |
| en_link | input | N_LINK | Enable bits of the link outputs |
| en_agp | input | N_AGP | Enable bits of the graphics outputs |
| en_pci | input | N_PCI_FREE+N_PCI_GATED | Enable bits of the PCI outputs; the low N_PCI_FREE bits belong to the free-running outputs |
| en_apic | input | N_APIC | Enable bits of the interrupt controller outputs |
| en_ref | input | N_REF | Enable bits of the reference outputs |
| en_usb | input | 1 | Enable bit of the USB output |
| en_aux | input | 1 | Enable bit of the auxiliary output |
| cpu_halt_mask | input | N_CPU | 1 lets `cpu_halt_n` stop that processor output |
| hiz_all | input | 1 | Tri-state override of every output |
| aux_half_rate | input | 1 | 1 selects half rate for `aux_clk`, 0 selects full rate |
| usb_invert | input | 1 | 1 puts `usb_clk` in antiphase to `src_48m` |
| cpu_clk | output | N_CPU | Gated processor clocks |
| link_clk | output | N_LINK | Gated link clocks |
| agp_clk | output | N_AGP | Gated graphics clocks |
| pci_clk | output | N_PCI_FREE+N_PCI_GATED | Gated PCI clocks; the low N_PCI_FREE bits are free-running |
| apic_clk | output | N_APIC | Gated interrupt controller clocks |
| ref_clk | output | N_REF | Gated reference clocks |
| usb_clk | output | 1 | Gated USB clock |
| aux_clk | output | 1 | Gated auxiliary clock at the selected rate |
| clk_oe | output | 1 | Pad output enable; 0 releases every clock output |

## Verification
Two functions can meet inside the same source cycle on one gate: the power-down or tri-state override and a group stop pin or enable bit. On the auxiliary output, a rate change can also meet an enable change. The random phase moves the enables, both stop pins, the mask, power-down and the override together in one step, at instants offset from every clock edge. After settling, each output's activity is compared with a bench function that applies the priority order. A directed run toggles `aux_half_rate` several times while `aux_clk` runs. Pulse-width monitors on all outputs check, over the whole run, that no collision ever produced a high pulse shorter than the source allows.

// File: rtl/clkout_pkg.sv
`timescale 1ns/1ps
package clkout_pkg;

  // Gate condition of one output: the enable bit must be set, no stop may
  // hit it, power must be up and the tri-state override must be clear.
  function automatic logic gate_open(input logic en_bit,
                                     input logic halt_hit,
                                     input logic pwr_ok,
                                     input logic hiz);
    return en_bit & ~halt_hit & pwr_ok & ~hiz;
  endfunction

  // A rate hand-off is safe only while the half-rate clock sits low.
  function automatic logic handoff_safe(input logic half_level);
    return ~half_level;
  endfunction

endpackage

// File: rtl/clkout_sync2.sv
`timescale 1ns/1ps
module clkout_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/clkout_icg.sv
`timescale 1ns/1ps
module clkout_icg (
  input  logic clk_src,
  input  logic en,
  output logic clk_out,
  output logic en_held
);
  logic en_l;

  // Transparent only while the source is low, so the AND never sees an
  // enable edge during a high phase.
  always_latch begin
    if (!clk_src) en_l <= en;
  end

  assign clk_out = clk_src & en_l;
  assign en_held = en_l;
endmodule

// File: rtl/clkout_rate_sel.sv
`timescale 1ns/1ps
module clkout_rate_sel import clkout_pkg::*; (
  input  logic clk_fast,
  input  logic rst_n,
  input  logic slow_req,
  output logic clk_sel
);
  logic half_q;
  logic req_s1_q;
  logic slow_q;
  logic swap_ok;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= ~half_q;
  end

  assign swap_ok = handoff_safe(half_q);

  // Select is captured at the falling edge of the fast clock, and only
  // taken when the half-rate clock is low too: both candidates are low.
  always_ff @(negedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      req_s1_q <= 1'b1;
      slow_q   <= 1'b1;
    end else begin
      req_s1_q <= slow_req;
      if (swap_ok) slow_q <= req_s1_q;
    end
  end

  assign clk_sel = slow_q ? half_q : clk_fast;

  // R6: a select change is seen at a rising edge only after a low half phase
  assert_rate_swap_low_R6: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (slow_q != $past(slow_q)) |-> !half_q)
    else $error("rate select changed while half-rate clock high");
endmodule

// File: rtl/clkout_group.sv
`timescale 1ns/1ps
module clkout_group import clkout_pkg::*; #(
  parameter int N = 2
) (
  input  logic         clk_sync,
  input  logic         rst_n,
  input  logic [N-1:0] clk_gate,
  input  logic [N-1:0] en_bits,
  input  logic [N-1:0] halt_mask,
  input  logic         halt_n,
  input  logic         pwrdn_n,
  input  logic         hiz,
  output logic [N-1:0] clk_out
);
  logic pwr_ok;
  logic run_ok;
  logic halt_req;
  logic [N-1:0] en_next;
  logic [N-1:0] en_held;

  clkout_sync2 u_sync_pwr (
    .clk   (clk_sync),
    .rst_n (rst_n),
    .d     (pwrdn_n),
    .q     (pwr_ok)
  );

  clkout_sync2 u_sync_halt (
    .clk   (clk_sync),
    .rst_n (rst_n),
    .d     (halt_n),
    .q     (run_ok)
  );

  assign halt_req = ~run_ok;

  for (genvar i = 0; i < N; i++) begin : g_out
    assign en_next[i] = gate_open(en_bits[i], halt_req & halt_mask[i], pwr_ok, hiz);

    clkout_icg u_icg (
      .clk_src (clk_gate[i]),
      .en      (en_next[i]),
      .clk_out (clk_out[i]),
      .en_held (en_held[i])
    );

    // R1: an enable bit held at 0 leaves the gate closed
    assert_enable_closes_R1: assert property (@(posedge clk_sync) disable iff (!rst_n)
      (!en_bits[i] && !$past(en_bits[i])) |-> !en_held[i])
      else $error("gate %0d open with enable bit clear", i);

    // R3 (and R2 through the PCI mask): a masked stop closes the gate
    assert_halt_closes_R3: assert property (@(posedge clk_sync) disable iff (!rst_n)
      (halt_req && $past(halt_req) && halt_mask[i] && $past(halt_mask[i])) |-> !en_held[i])
      else $error("gate %0d open during stop", i);

    // R4: tri-state override closes every gate
    assert_hiz_closes_R4: assert property (@(posedge clk_sync) disable iff (!rst_n)
      (hiz && $past(hiz)) |-> !en_held[i])
      else $error("gate %0d open during tri-state", i);

    // R5: synchronized power-down closes every gate
    assert_pwrdn_closes_R5: assert property (@(posedge clk_sync) disable iff (!rst_n)
      (!pwr_ok && !$past(pwr_ok)) |-> !en_held[i])
      else $error("gate %0d open during power-down", i);
  end
endmodule

// File: rtl/clkout_gate_ctrl.sv
`timescale 1ns/1ps
module clkout_gate_ctrl #(
  parameter int N_CPU       = 2,
  parameter int N_LINK      = 2,
  parameter int N_AGP       = 2,
  parameter int N_PCI_FREE  = 2,
  parameter int N_PCI_GATED = 6,
  parameter int N_APIC      = 2,
  parameter int N_REF       = 3
) (
  input  logic                                rst_n,
  input  logic                                src_cpu,
  input  logic                                src_link,
  input  logic                                src_agp,
  input  logic                                src_pci,
  input  logic                                src_apic,
  input  logic                                src_48m,
  input  logic                                src_ref,
  input  logic                                pwrdn_n,
  input  logic                                pci_halt_n,
  input  logic                                cpu_halt_n,
  input  logic [N_CPU-1:0]                    en_cpu,
  input  logic [N_LINK-1:0]                   en_link,
  input  logic [N_AGP-1:0]                    en_agp,
  input  logic [N_PCI_FREE+N_PCI_GATED-1:0]   en_pci,
  input  logic [N_APIC-1:0]                   en_apic,
  input  logic [N_REF-1:0]                    en_ref,
  input  logic                                en_usb,
  input  logic                                en_aux,
  input  logic [N_CPU-1:0]                    cpu_halt_mask,
  input  logic                                hiz_all,
  input  logic                                aux_half_rate,
  input  logic                                usb_invert,
  output logic [N_CPU-1:0]                    cpu_clk,
  output logic [N_LINK-1:0]                   link_clk,
  output logic [N_AGP-1:0]                    agp_clk,
  output logic [N_PCI_FREE+N_PCI_GATED-1:0]   pci_clk,
  output logic [N_APIC-1:0]                   apic_clk,
  output logic [N_REF-1:0]                    ref_clk,
  output logic                                usb_clk,
  output logic                                aux_clk,
  output logic                                clk_oe
);
  localparam int N_PCI = N_PCI_FREE + N_PCI_GATED;
  localparam logic [N_PCI-1:0] PCI_HALT_MASK = {{N_PCI_GATED{1'b1}}, {N_PCI_FREE{1'b0}}};

  logic usb_src;
  logic aux_src;
  logic [1:0] f48_out;

  assign clk_oe = ~hiz_all;

  clkout_group #(.N(N_CPU)) u_grp_cpu (
    .clk_sync (src_cpu), .rst_n (rst_n), .clk_gate ({N_CPU{src_cpu}}),
    .en_bits (en_cpu), .halt_mask (cpu_halt_mask), .halt_n (cpu_halt_n),
    .pwrdn_n (pwrdn_n), .hiz (hiz_all), .clk_out (cpu_clk)
  );

  clkout_group #(.N(N_LINK)) u_grp_link (
    .clk_sync (src_link), .rst_n (rst_n), .clk_gate ({N_LINK{src_link}}),
    .en_bits (en_link), .halt_mask ('0), .halt_n (1'b1),
    .pwrdn_n (pwrdn_n), .hiz (hiz_all), .clk_out (link_clk)
  );

  clkout_group #(.N(N_AGP)) u_grp_agp (
    .clk_sync (src_agp), .rst_n (rst_n), .clk_gate ({N_AGP{src_agp}}),
    .en_bits (en_agp), .halt_mask ('0), .halt_n (1'b1),
    .pwrdn_n (pwrdn_n), .hiz (hiz_all), .clk_out (agp_clk)
  );

  clkout_group #(.N(N_PCI)) u_grp_pci (
    .clk_sync (src_pci), .rst_n (rst_n), .clk_gate ({N_PCI{src_pci}}),
    .en_bits (en_pci), .halt_mask (PCI_HALT_MASK), .halt_n (pci_halt_n),
    .pwrdn_n (pwrdn_n), .hiz (hiz_all), .clk_out (pci_clk)
  );

  clkout_group #(.N(N_APIC)) u_grp_apic (
    .clk_sync (src_apic), .rst_n (rst_n), .clk_gate ({N_APIC{src_apic}}),
    .en_bits (en_apic), .halt_mask ('0), .halt_n (1'b1),
    .pwrdn_n (pwrdn_n), .hiz (hiz_all), .clk_out (apic_clk)
  );

  clkout_group #(.N(N_REF)) u_grp_ref (
    .clk_sync (src_ref), .rst_n (rst_n), .clk_gate ({N_REF{src_ref}}),
    .en_bits (en_ref), .halt_mask ('0), .halt_n (1'b1),
    .pwrdn_n (pwrdn_n), .hiz (hiz_all), .clk_out (ref_clk)
  );

  // 48 MHz domain: USB copy (optionally in antiphase) and the rate-selected
  // auxiliary output share one set of synchronizers.
  assign usb_src = src_48m ^ usb_invert;

  clkout_rate_sel u_rate (
    .clk_fast (src_48m),
    .rst_n    (rst_n),
    .slow_req (aux_half_rate),
    .clk_sel  (aux_src)
  );

  clkout_group #(.N(2)) u_grp_48m (
    .clk_sync (src_48m), .rst_n (rst_n), .clk_gate ({aux_src, usb_src}),
    .en_bits ({en_aux, en_usb}), .halt_mask (2'b00), .halt_n (1'b1),
    .pwrdn_n (pwrdn_n), .hiz (hiz_all), .clk_out (f48_out)
  );

  assign usb_clk = f48_out[0];
  assign aux_clk = f48_out[1];
endmodule

// File: tb/clkout_gate_ctrl_bench.sv
`timescale 1ns/1ps
module clkout_pulse_mon (
  input  logic sig,
  input  int   half_a,
  input  int   half_b,
  output int   edges,
  output int   bad
);
  int      n_edge = 0;
  int      n_bad  = 0;
  realtime t_rise = 0.0;
  bit      seen   = 1'b0;

  function automatic bit near(realtime w, int h);
    return (w > real'(h) - 0.01) && (w < real'(h) + 0.01);
  endfunction

  always @(posedge sig) begin
    n_edge = n_edge + 1;
    t_rise = $realtime;
    seen   = 1'b1;
  end

  always @(negedge sig) begin
    if (seen && !near($realtime - t_rise, half_a) && !near($realtime - t_rise, half_b))
      n_bad = n_bad + 1;
  end

  assign edges = n_edge;
  assign bad   = n_bad;
endmodule

module clkout_gate_ctrl_bench;
  localparam real CLK_PERIOD = 20.0;            // PCI source period
  localparam real P_CPU  = CLK_PERIOD * 0.3;    // 6 ns
  localparam real P_LINK = CLK_PERIOD * 0.4;    // 8 ns
  localparam real P_AGP  = CLK_PERIOD * 0.6;    // 12 ns
  localparam real P_APIC = CLK_PERIOD * 0.8;    // 16 ns
  localparam real P_48M  = CLK_PERIOD * 0.5;    // 10 ns
  localparam real P_REF  = CLK_PERIOD * 0.7;    // 14 ns
  localparam int  N_OUT  = 21;

  logic src_cpu = 0, src_link = 0, src_agp = 0, src_pci = 0;
  logic src_apic = 0, src_48m = 0, src_ref = 0;
  logic rst_n = 1'b1;
  logic pwrdn_n = 1'b1, pci_halt_n = 1'b1, cpu_halt_n = 1'b1;
  logic [N_OUT-1:0] en_all = '1;
  logic [1:0] halt_mask = 2'b11;
  logic hiz_all = 1'b0, aux_half_rate = 1'b1, usb_invert = 1'b0;

  logic [1:0] cpu_clk, link_clk, agp_clk, apic_clk;
  logic [7:0] pci_clk;
  logic [2:0] ref_clk;
  logic usb_clk, aux_clk, clk_oe;
  logic [N_OUT-1:0] all_out;

  int n_checks = 0;
  int n_err    = 0;
  int edge_cnt [N_OUT];
  int bad_cnt  [N_OUT];

  initial forever #(P_CPU/2)      src_cpu  = ~src_cpu;
  initial forever #(P_LINK/2)     src_link = ~src_link;
  initial forever #(P_AGP/2)      src_agp  = ~src_agp;
  initial forever #(CLK_PERIOD/2) src_pci  = ~src_pci;
  initial forever #(P_APIC/2)     src_apic = ~src_apic;
  initial forever #(P_48M/2)      src_48m  = ~src_48m;
  initial forever #(P_REF/2)      src_ref  = ~src_ref;

  clkout_gate_ctrl u_clkout_gate_ctrl (
    .rst_n (rst_n),
    .src_cpu (src_cpu), .src_link (src_link), .src_agp (src_agp), .src_pci (src_pci),
    .src_apic (src_apic), .src_48m (src_48m), .src_ref (src_ref),
    .pwrdn_n (pwrdn_n), .pci_halt_n (pci_halt_n), .cpu_halt_n (cpu_halt_n),
    .en_cpu (en_all[1:0]), .en_link (en_all[3:2]), .en_agp (en_all[5:4]),
    .en_pci (en_all[13:6]), .en_apic (en_all[15:14]), .en_ref (en_all[18:16]),
    .en_usb (en_all[19]), .en_aux (en_all[20]),
    .cpu_halt_mask (halt_mask), .hiz_all (hiz_all),
    .aux_half_rate (aux_half_rate), .usb_invert (usb_invert),
    .cpu_clk (cpu_clk), .link_clk (link_clk), .agp_clk (agp_clk), .pci_clk (pci_clk),
    .apic_clk (apic_clk), .ref_clk (ref_clk), .usb_clk (usb_clk), .aux_clk (aux_clk),
    .clk_oe (clk_oe)
  );

  assign all_out = {aux_clk, usb_clk, ref_clk, apic_clk, pci_clk, agp_clk, link_clk, cpu_clk};

  // Source high width of each output index, in ns.
  function automatic int half_of(int idx);
    if (idx < 2)  return 3;
    if (idx < 4)  return 4;
    if (idx < 6)  return 6;
    if (idx < 14) return 10;
    if (idx < 16) return 8;
    if (idx < 19) return 7;
    return 5;
  endfunction

  for (genvar g = 0; g < N_OUT; g++) begin : g_mon
    clkout_pulse_mon u_mon (
      .sig (all_out[g]), .half_a (half_of(g)), .half_b ((g == 20) ? 10 : half_of(g)),
      .edges (edge_cnt[g]), .bad (bad_cnt[g])
    );
  end

  // Expected activity from the priority rules: override, power, stop, enable.
  function automatic bit exp_run(int idx);
    bit hit;
    hit = 1'b0;
    if (idx == 0) hit = !cpu_halt_n && halt_mask[0];
    if (idx == 1) hit = !cpu_halt_n && halt_mask[1];
    if (idx >= 8 && idx <= 13) hit = !pci_halt_n;
    return en_all[idx] && !hit && pwrdn_n && !hiz_all;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // 1 = toggling, 2 = stuck high, 0 = stuck low
  task automatic measure_all(string req);
    int snap [N_OUT];
    #120;
    for (int i = 0; i < N_OUT; i++) snap[i] = edge_cnt[i];
    #200;
    for (int i = 0; i < N_OUT; i++)
      check(req, $sformatf("output %0d activity", i),
            ((edge_cnt[i] - snap[i]) > 0) ? 1 : (all_out[i] ? 2 : 0),
            exp_run(i) ? 1 : 0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 10000);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int snap;
    int total_bad;
    void'($urandom(32'h00c1_0c4e));
    #0.5;
    rst_n = 1'b0;
    #40;
    // R10: reset state
    check("R10", "outputs in reset", int'(all_out), 0);
    check("R10", "oe in reset", int'(clk_oe), 1);
    rst_n = 1'b1;

    measure_all("R1");

    pci_halt_n = 1'b0;                 // R2: free pair keeps running
    measure_all("R2");
    pci_halt_n = 1'b1;

    halt_mask = 2'b01;                 // R3: only cpu_clk[0] obeys the stop
    cpu_halt_n = 1'b0;
    measure_all("R3");
    cpu_halt_n = 1'b1;
    halt_mask = 2'b11;

    pwrdn_n = 1'b0;                    // R5: power-down beats enables
    measure_all("R5");
    check("R5", "oe during power-down", int'(clk_oe), 1);
    pwrdn_n = 1'b1;

    hiz_all = 1'b1;                    // R4: override beats everything
    pwrdn_n = 1'b0;
    measure_all("R4");
    check("R4", "oe during tri-state", int'(clk_oe), 0);
    hiz_all = 1'b0;
    pwrdn_n = 1'b1;
    #1;
    check("R4", "oe after tri-state", int'(clk_oe), 1);

    // R8: two synchronizer stages of latency on cpu_clk[0]
    #120;
    snap = edge_cnt[0];
    pwrdn_n = 1'b0;
    #60;
    check("R8", "cpu edges after power-down", edge_cnt[0] - snap, 2);
    snap = edge_cnt[0];
    pwrdn_n = 1'b1;
    #11;
    check("R8", "cpu edges just after release", edge_cnt[0] - snap, 0);

    // R6: auxiliary rate, with live switches in between
    aux_half_rate = 1'b1;
    #120;
    snap = edge_cnt[20];
    #200;
    check("R6", "aux edges at half rate", edge_cnt[20] - snap, 10);
    for (int k = 0; k < 6; k++) begin
      aux_half_rate = ~aux_half_rate;
      #(13 + 2 * k);
    end
    aux_half_rate = 1'b0;
    #120;
    snap = edge_cnt[20];
    #200;
    check("R6", "aux edges at full rate", edge_cnt[20] - snap, 20);
    aux_half_rate = 1'b1;

    // R7: antiphase USB, changed only while its gate is off
    en_all[19] = 1'b0;
    #60;
    usb_invert = 1'b1;
    #60;
    en_all[19] = 1'b1;
    #60;
    @(posedge src_48m);
    #2;
    check("R7", "inverted usb in source high", int'(usb_clk), 0);
    #5;
    check("R7", "inverted usb in source low", int'(usb_clk), 1);
    #0.5;
    en_all[19] = 1'b0;
    #60;
    usb_invert = 1'b0;
    #60;
    en_all[19] = 1'b1;
    #60;
    @(posedge src_48m);
    #2;
    check("R7", "plain usb in source high", int'(usb_clk), 1);
    #0.5;

    // Random mixes of every control, R1 plus the priority of R2..R5
    for (int it = 0; it < 14; it++) begin
      en_all     = N_OUT'($urandom | $urandom);
      cpu_halt_n = ($urandom % 3) != 0;
      pci_halt_n = ($urandom % 3) != 0;
      pwrdn_n    = ($urandom % 6) != 0;
      hiz_all    = ($urandom % 8) == 0;
      halt_mask  = 2'($urandom);
      measure_all("R1");
      check("R4", "oe in random mix", int'(clk_oe), hiz_all ? 0 : 1);
    end

    // R9: no truncated pulse anywhere during the run
    total_bad = 0;
    for (int i = 0; i < N_OUT; i++) total_bad += bad_cnt[i];
    check("R9", "short high pulses", total_bad, 0);

    finish_run();
  end
endmodule